// File: doc/BRIEF.md
# Multi-channel down-counting interval timer

This block holds six independent 32-bit down-counters behind one 32-bit register port. Each channel has its own control word, its own reload value and a current count that software can read and write. A channel counts down on ticks from one of four tick-enable inputs. A prescaler can slow those ticks by a power of two. The channel either stops when it reaches zero, or reloads and runs again.

Every channel that reaches zero raises its own bit in a shared pending register. Software clears a bit by writing 1 to it. A shared enable register masks each channel's bit before all of them are ORed onto one registered interrupt line. Clock generation lives outside the block: each clock source arrives as a one-cycle tick-enable input on the block's own clock.

Top module: `itimer_bank`

## Requirements
- R1: After a synchronous reset every register (enable, pending, and each channel's control, reload and count) reads zero, and `irq` is low.
- R2: Register layout, by byte address:
  - The enable register is at 0x00 and the pending register at 0x04. Bit n of each belongs to channel n.
  - Channel n has its control register at 0x10+0x10·n, its reload register at 0x14+0x10·n and its count register at 0x18+0x10·n.
  - Any other address reads zero.
  - `bus_rdata` is loaded on the clock edge that samples `bus_rd`. It holds the register value as it stood before that edge.
- R3: Control word layout:
  - bit 0 is run (1 starts the channel, 0 stops it);
  - bit 1 is reload;
  - bits 3:2 are the tick source;
  - bits 6:4 are the prescaler;
  - bit 7 is single-shot.
  - Reading the register returns the word that was written, except that the run bit may have been cleared by hardware.
- R4: A running channel decrements its count by one on each divided tick. A stopped channel's count changes only when software writes it.
- R5: Source field value s selects `tick_src[s]`. Value 1 is the main oscillator tick. A channel whose selected source never ticks keeps its count.
- R6: Prescaler field p passes one tick in every 2^p ticks of the selected source. The divider restarts when the channel starts, so the first decrement comes on the 2^p-th source tick after the start.
- R7: A decrement from 1 to 0 sets the channel's pending bit.
- R8: When the single-shot bit is 1 or the reload bit is 0, the expiry also clears the run bit, and the count stays at 0.
- R9: When the reload bit is 1 and the single-shot bit is 0, the tick after the count reaches 0 loads the reload value and the channel keeps running. A reload value of 0xFFFFFFFF therefore wraps the count from 0 to 0xFFFFFFFF.
- R10: A write to a channel's count register takes effect at once. A tick in the same cycle is discarded, and counting carries on from the written value.
- R11: Writing 1 to a pending bit clears it, and writing 0 leaves it alone. An expiry in the same cycle as a clear leaves the bit set.
- R12: `irq` is the OR over all channels of (pending AND enable), registered, so it follows those registers one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src | input | 4 | Tick-enable inputs, one per clock source; index 1 is the main oscillator |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker assumes the following about the inputs:
- a channel's count changes only through its own tick logic or a write to its count register;
- a control write is the only thing that can set the run bit;
- reset is applied before the first checked edge.

The stimulus keeps within these assumptions:
- it changes inputs only on the falling clock edge;
- it holds each bus strobe for exactly one cycle and uses only word-aligned addresses;
- it stops a channel before rewriting that channel's reload and count values.

Random runs use the sources that tick every cycle, so the expected count follows directly from the cycle count and the prescaler. Directed cases place a pending clear on the exact expiry edge, and a count write on a cycle that also carries a tick.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  // Fixed register offsets (bytes)
  localparam int OFS_IRQ_EN   = 'h00;
  localparam int OFS_IRQ_PEND = 'h04;
  localparam int OFS_CH_BASE  = 'h10;
  localparam int CH_STRIDE    = 'h10;
  localparam int OFS_CTRL     = 'h0;
  localparam int OFS_INTV     = 'h4;
  localparam int OFS_CUR      = 'h8;

  localparam int SRC_SEL_W = 2;
  localparam int PRE_W     = 3;
  localparam int CTRL_W    = 8;

  // Control word, msb first: single, prescale, source, reload, run
  typedef struct packed {
    logic                 single;
    logic [PRE_W-1:0]     pre;
    logic [SRC_SEL_W-1:0] src;
    logic                 reload;
    logic                 run;
  } ctrl_t;

endpackage

// File: rtl/itimer_prescaler.sv
module itimer_prescaler #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2,
  parameter int PRE_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [PRE_W-1:0]   pre,
  output logic               tick_out
);

  localparam int DIV_W = (1 << PRE_W) - 1;

  logic             src_tick;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_mask;

  // Source multiplexer
  always_comb begin
    src_tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sel == SEL_W'(i)) src_tick = tick_src[i];
    end
  end

  // Mask of the low prescaler bits that must all be one
  always_comb div_mask = DIV_W'((32'd1 << pre) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst || clr) div_cnt <= '0;
    else if (src_tick) div_cnt <= div_cnt + 1'b1;
  end

  assign tick_out = src_tick && !clr && ((div_cnt & div_mask) == div_mask);

endmodule

// File: rtl/itimer_channel.sv
module itimer_channel
  import itimer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic               ctrl_wr,
  input  logic               intv_wr,
  input  logic               cur_wr,
  input  logic [DATA_W-1:0]  wdata,
  output ctrl_t              ctrl_q,
  output logic [CNT_W-1:0]   intv_q,
  output logic [CNT_W-1:0]   cur_q,
  output logic               expire
);

  logic div_tick;
  logic step;
  logic at_zero;
  logic at_one;
  logic reload_mode;

  itimer_prescaler #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SRC_SEL_W),
    .PRE_W   (PRE_W)
  ) u_prescaler (
    .clk      (clk),
    .rst      (rst),
    .clr      (!ctrl_q.run),
    .tick_src (tick_src),
    .src_sel  (ctrl_q.src),
    .pre      (ctrl_q.pre),
    .tick_out (div_tick)
  );

  // A software write to this channel's control or count cancels the tick
  assign step        = ctrl_q.run && div_tick && !ctrl_wr && !cur_wr;
  assign at_zero     = (cur_q == '0);
  assign at_one      = (cur_q == CNT_W'(1));
  assign reload_mode = ctrl_q.reload && !ctrl_q.single;
  assign expire      = step && at_one;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      intv_q <= '0;
      cur_q  <= '0;
    end else begin
      if (intv_wr) intv_q <= wdata[CNT_W-1:0];

      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (step && !reload_mode && (at_one || at_zero)) ctrl_q.run <= 1'b0;

      if (cur_wr) begin
        cur_q <= wdata[CNT_W-1:0];
      end else if (step) begin
        if (!at_zero) cur_q <= cur_q - 1'b1;
        else if (reload_mode) cur_q <= intv_q;
      end
    end
  end

endmodule

// File: rtl/itimer_bank.sv
module itimer_bank
  import itimer_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int CNT_W   = 32,
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq
);

  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_IRQ_EN);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_IRQ_PEND);

  logic [NUM_CH-1:0]            irq_en_q;
  logic [NUM_CH-1:0]            irq_pend_q;
  ctrl_t [NUM_CH-1:0]           ch_ctrl;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_intv;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cur;
  logic [NUM_CH-1:0]            ch_expire;
  logic [NUM_CH-1:0]            ch_ctrl_wr;
  logic [NUM_CH-1:0]            ch_intv_wr;
  logic [NUM_CH-1:0]            ch_cur_wr;
  logic [NUM_CH-1:0]            ch_run;
  logic [NUM_CH-1:0]            ch_reload;
  logic [NUM_CH-1:0]            ch_single;
  logic [NUM_CH-1:0]            pend_clr;
  logic [DATA_W-1:0]            rd_val;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CH_BASE + g * CH_STRIDE + OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_INTV = ADDR_W'(OFS_CH_BASE + g * CH_STRIDE + OFS_INTV);
    localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFS_CH_BASE + g * CH_STRIDE + OFS_CUR);

    assign ch_ctrl_wr[g] = bus_wr && (bus_addr == A_CTRL);
    assign ch_intv_wr[g] = bus_wr && (bus_addr == A_INTV);
    assign ch_cur_wr[g]  = bus_wr && (bus_addr == A_CUR);

    itimer_channel #(
      .CNT_W   (CNT_W),
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_SRC)
    ) u_channel (
      .clk      (clk),
      .rst      (rst),
      .tick_src (tick_src),
      .ctrl_wr  (ch_ctrl_wr[g]),
      .intv_wr  (ch_intv_wr[g]),
      .cur_wr   (ch_cur_wr[g]),
      .wdata    (bus_wdata),
      .ctrl_q   (ch_ctrl[g]),
      .intv_q   (ch_intv[g]),
      .cur_q    (ch_cur[g]),
      .expire   (ch_expire[g])
    );

    assign ch_run[g]    = ch_ctrl[g].run;
    assign ch_reload[g] = ch_ctrl[g].reload;
    assign ch_single[g] = ch_ctrl[g].single;
  end

  // Write-one-to-clear mask; a same-cycle expiry overrides it
  assign pend_clr = (bus_wr && bus_addr == A_PEND) ? bus_wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q   <= '0;
      irq_pend_q <= '0;
      irq        <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_EN) irq_en_q <= bus_wdata[NUM_CH-1:0];
      irq_pend_q <= (irq_pend_q & ~pend_clr) | ch_expire;
      irq        <= |(irq_pend_q & irq_en_q);
    end
  end

  // Read multiplexer
  always_comb begin
    rd_val = '0;
    if (bus_addr == A_EN)   rd_val[NUM_CH-1:0] = irq_en_q;
    if (bus_addr == A_PEND) rd_val[NUM_CH-1:0] = irq_pend_q;
    for (int g = 0; g < NUM_CH; g++) begin
      if (bus_addr == ADDR_W'(OFS_CH_BASE + g * CH_STRIDE + OFS_CTRL))
        rd_val[CTRL_W-1:0] = ch_ctrl[g];
      if (bus_addr == ADDR_W'(OFS_CH_BASE + g * CH_STRIDE + OFS_INTV))
        rd_val[CNT_W-1:0] = ch_intv[g];
      if (bus_addr == ADDR_W'(OFS_CH_BASE + g * CH_STRIDE + OFS_CUR))
        rd_val[CNT_W-1:0] = ch_cur[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

endmodule

// File: rtl/itimer_checker.sv
module itimer_checker
  import itimer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            bus_wr,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [DATA_W-1:0]               bus_wdata,
  input logic                            irq,
  input logic [NUM_CH-1:0]               irq_en_q,
  input logic [NUM_CH-1:0]               irq_pend_q,
  input logic [NUM_CH-1:0]               ch_expire,
  input logic [NUM_CH-1:0]               ch_run,
  input logic [NUM_CH-1:0]               ch_reload,
  input logic [NUM_CH-1:0]               ch_single,
  input logic [NUM_CH-1:0]               ch_cur_wr,
  input logic [NUM_CH-1:0][CNT_W-1:0]    ch_cur
);

  logic pend_wr;
  assign pend_wr = bus_wr && (bus_addr == ADDR_W'(OFS_IRQ_PEND));

  AST_IRQ_FOLLOWS_SET: assert property (@(posedge clk) disable iff (rst)
    (|(irq_pend_q & irq_en_q)) |=> irq); // R12
  AST_IRQ_FOLLOWS_CLR: assert property (@(posedge clk) disable iff (rst)
    !(|(irq_pend_q & irq_en_q)) |=> !irq); // R12

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_EXPIRE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
      ch_expire[g] |=> irq_pend_q[g]); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
      (irq_pend_q[g] && !(pend_wr && bus_wdata[g])) |=> irq_pend_q[g]); // R11
    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
      (ch_expire[g] && (ch_single[g] || !ch_reload[g])) |=> !ch_run[g]); // R8
    AST_RELOAD_RUNS: assert property (@(posedge clk) disable iff (rst)
      (ch_expire[g] && ch_reload[g] && !ch_single[g]) |=> ch_run[g]); // R9
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!ch_run[g] && !ch_cur_wr[g]) |=> $stable(ch_cur[g])); // R4
    AST_EXPIRE_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
      ch_expire[g] |=> (ch_cur[g] == '0)); // R7
  end

endmodule

bind itimer_bank itimer_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .irq_en_q   (irq_en_q),
  .irq_pend_q (irq_pend_q),
  .ch_expire  (ch_expire),
  .ch_run     (ch_run),
  .ch_reload  (ch_reload),
  .ch_single  (ch_single),
  .ch_cur_wr  (ch_cur_wr),
  .ch_cur     (ch_cur)
);

// File: tb/test_itimer_bank.sv
module test_itimer_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  tick_src = 4'b0011;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  itimer_bank i_itimer_bank (
    .clk       (clk),
    .rst       (rst),
    .tick_src  (tick_src),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic logic [7:0] a_ctrl(input int ch); return 8'(8'h10 + 8'h10 * ch); endfunction
  function automatic logic [7:0] a_intv(input int ch); return 8'(8'h14 + 8'h10 * ch); endfunction
  function automatic logic [7:0] a_cur(input int ch);  return 8'(8'h18 + 8'h10 * ch); endfunction

  // Expected count after n divided ticks from a start value
  function automatic logic [31:0] model_cur(input longint unsigned start, input longint unsigned intv,
                                            input bit reload, input longint unsigned n);
    longint unsigned t;
    if (n <= start) return 32'(start - n);
    if (!reload) return 32'd0;
    t = n - start - 1;
    return 32'(intv - (t % (intv + 1)));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Callers are positioned just after a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    bus_read(8'h00, rv); check("R1 enable", rv, 32'd0);
    bus_read(8'h04, rv); check("R1 pending", rv, 32'd0);
    for (int c = 0; c < 6; c++) begin
      bus_read(a_ctrl(c), rv); check("R1 ctrl", rv, 32'd0);
      bus_read(a_cur(c), rv);  check("R1 count", rv, 32'd0);
    end

    // R2 register layout and unmapped addresses
    bus_write(a_intv(3), 32'hCAFE0003);
    bus_write(a_intv(4), 32'h1234ABCD);
    bus_read(a_intv(3), rv); check("R2 reload ch3", rv, 32'hCAFE0003);
    bus_read(a_intv(4), rv); check("R2 reload ch4", rv, 32'h1234ABCD);
    bus_read(8'h08, rv); check("R2 unmapped 0x08", rv, 32'd0);
    bus_read(8'h70, rv); check("R2 unmapped 0x70", rv, 32'd0);
    bus_read(8'h1C, rv); check("R2 unmapped 0x1C", rv, 32'd0);

    // R7 R11: expiry on the same edge as a pending clear
    bus_write(a_cur(0), 32'd3);
    bus_write(a_ctrl(0), 32'h01);          // run, one-shot, source 0, div 1
    repeat (2) @(negedge clk);
    bus_write(8'h04, 32'h01);              // clear lands on the expiry edge
    bus_read(8'h04, rv); check("R11 set wins over clear", rv, 32'h01);
    bus_read(a_ctrl(0), rv); check("R8 run cleared", rv, 32'h00);
    bus_write(8'h04, 32'h00);
    bus_read(8'h04, rv); check("R11 write zero keeps bit", rv, 32'h01);

    // R12 irq latency
    check("R12 irq masked", {31'd0, irq}, 32'd0);
    bus_write(8'h00, 32'h01);
    @(negedge clk);
    check("R12 irq raised", {31'd0, irq}, 32'd1);
    bus_write(8'h04, 32'h01);
    check("R12 irq one cycle late", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R12 irq dropped", {31'd0, irq}, 32'd0);
    bus_read(8'h04, rv); check("R11 cleared", rv, 32'd0);
    bus_write(8'h00, 32'h00);

    // R9 full-range wrap
    bus_write(a_intv(5), 32'hFFFFFFFF);
    bus_write(a_cur(5), 32'd1);
    bus_write(a_ctrl(5), 32'h03);
    repeat (4) @(negedge clk);
    bus_read(a_cur(5), rv); check("R9 wrap", rv, 32'hFFFFFFFD);
    bus_read(a_ctrl(5), rv); check("R9 still running", rv, 32'h03);
    bus_write(a_ctrl(5), 32'h00);

    // R8 R3 single-shot bit overrides reload
    bus_write(a_cur(4), 32'd2);
    bus_write(a_ctrl(4), 32'h83);
    repeat (10) @(negedge clk);
    bus_read(a_cur(4), rv); check("R8 holds zero", rv, 32'd0);
    bus_read(a_ctrl(4), rv); check("R3 ctrl readback", rv, 32'h82);

    // R5 source selection
    bus_write(a_cur(3), 32'd50);
    bus_write(a_ctrl(3), 32'h09);          // source 2 never ticks
    repeat (20) @(negedge clk);
    bus_read(a_cur(3), rv); check("R5 silent source holds", rv, 32'd50);
    bus_write(a_ctrl(3), 32'h05);          // source 1, main oscillator
    repeat (10) @(negedge clk);
    bus_read(a_cur(3), rv); check("R5 main oscillator counts", rv, 32'd40);
    bus_write(a_ctrl(3), 32'h00);

    // R6 prescaler divide by 8
    bus_write(a_cur(1), 32'd100);
    bus_write(a_ctrl(1), 32'h31);
    repeat (23) @(negedge clk);
    bus_read(a_cur(1), rv); check("R6 divide by 8", rv, 32'd98);
    bus_write(a_ctrl(1), 32'h00);

    // R10 count write while running beats the tick
    bus_write(a_cur(2), 32'd1000);
    bus_write(a_ctrl(2), 32'h01);
    repeat (5) @(negedge clk);
    bus_write(a_cur(2), 32'd500);
    bus_read(a_cur(2), rv); check("R10 write wins", rv, 32'd500);
    bus_read(a_cur(2), rv); check("R10 counts on", rv, 32'd499);
    bus_write(a_ctrl(2), 32'h00);

    // R4 R6 R7 R8 R9 random runs against the bench model
    for (int it = 0; it < 40; it++) begin
      int ch, pre, k, sel;
      bit rl;
      longint unsigned st, iv, n;
      logic [31:0] cw;
      ch  = int'($urandom_range(5, 0));
      pre = int'($urandom_range(7, 0));
      k   = int'($urandom_range(400, 0));
      sel = int'($urandom_range(1, 0));
      rl  = 1'($urandom_range(1, 0));
      st  = longint'($urandom_range(60, 1));
      iv  = longint'($urandom_range(30, 0));
      cw  = rl ? (32'h03 | 32'(pre << 4) | 32'(sel << 2))
               : (32'h81 | 32'(pre << 4) | 32'(sel << 2));
      bus_write(a_ctrl(ch), 32'h00);
      bus_write(8'h04, 32'h3F);
      bus_write(a_intv(ch), 32'(iv));
      bus_write(a_cur(ch), 32'(st));
      bus_write(a_ctrl(ch), cw);
      repeat (k) @(negedge clk);
      n = longint'(k >> pre);
      bus_read(a_cur(ch), rv);
      check("R4 R6 R9 random count", rv, model_cur(st, iv, rl, n));
      n = longint'((k + 1) >> pre);
      bus_read(8'h04, rv);
      check("R7 random pending", {31'd0, rv[ch]}, {31'd0, (n >= st)});
      n = longint'((k + 2) >> pre);
      bus_read(a_ctrl(ch), rv);
      check("R8 random run bit", rv, (!rl && n >= st) ? (cw & ~32'h1) : cw);
      bus_write(a_ctrl(ch), 32'h00);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule